// File: doc/BRIEF.md
# Two-Wire Serial Debug Slave

This block is the slave end of a two-wire debug link. The link has one clock line driven by the master and one data line that either side may pull. A fast system clock samples both lines through a synchronizer. The block watches for a start condition: the data line falls while the clock line is high. Until it sees one, the block ignores all traffic. After a start, traffic moves in whole bytes. Each byte takes nine serial clocks: eight carry data, most-significant bit first, and the ninth is a gap in which the slave does its internal work.

The first byte after a start is a header, and its bit 0 sets the direction of the bytes that follow. The block delivers every received byte to the local side with a one-cycle strobe. During a read, the block takes each outgoing byte from the local side during the ninth clock. The data line is driven only through an output enable, so the pad can work as open drain.

A transaction ends when the master holds the clock line high in the ninth cycle. If it stays high for `HOLD_CYCLES` system clocks, the block returns to idle. The system clock must run at least four times faster than the serial clock.

Top module: `dbg2w_slave`

## Requirements
- R1: Before the first start condition, and while idle, clock pulses and data changes produce no `rx_valid`, no `tx_take` and no output enable.
- R2: A rise of the data line while the clock line is high has no effect. It neither starts nor resets a transaction, and it does not change a bit already sampled on the preceding clock rise.
- R3: In a write, the slave samples each bit on the rising serial clock, most-significant bit first. At the falling edge that opens the ninth cycle, it presents the byte on `rx_data` with a one-system-clock `rx_valid` pulse. `rx_hdr` is 1 for the header byte and 0 for every later byte.
- R4: If header bit 0 is 1 (read), the slave takes a byte from `tx_data` with a one-cycle `tx_take` pulse at the ninth cycle of the header and of every read byte. It shifts that byte out MSB first, changing `sda_o` after each falling serial clock edge.
- R5: If header bit 0 is 0 (write), every later byte of the transaction is delivered through `rx_valid`. During a read, the only byte reported through `rx_valid` is the header.
- R6: `sda_oe` is 1 only during the eight data cycles of a read byte. It is 0 in the ninth cycle, during write and header bytes, and while idle.
- R7: After the clock line stays high in the ninth cycle for `HOLD_CYCLES` system clocks, the slave is idle. Later bytes are ignored until a new start condition.
- R8: A start condition at any point, even in the middle of a byte, aborts the current transaction. The next byte is then treated as a new header.
- R9: After reset, `rx_valid`, `tx_take` and `sda_oe` are 0 and the slave is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Serial clock line from the master |
| sda_in | input | 1 | Data line as seen at the pad |
| sda_o | output | 1 | Data value to drive while `sda_oe` is 1 |
| sda_oe | output | 1 | Output enable for the data line |
| rx_data | output | 8 | Last received byte |
| rx_valid | output | 1 | One-cycle strobe: `rx_data` holds a new byte |
| rx_hdr | output | 1 | The byte under `rx_valid` is a header |
| tx_data | input | 8 | Next byte to send during a read |
| tx_take | output | 1 | One-cycle strobe: `tx_data` was captured |

## Verification
Write transactions use several headers and payloads, including all-ones and all-zero bytes, to separate MSB-first assembly from bit reversal or stuck bits. Read transactions under headers with bit 0 set confirm that direction comes from that bit alone. They also confirm that each loaded byte appears on the line in order and that the enable stays inside the data cycles. Traffic without a start, traffic after the hold timeout, a restart in the middle of a byte, and data rising during the high clock phase show that only a real falling-data start opens a transaction and that nothing else disturbs the framing.

// File: rtl/dbg2w_pkg.sv
package dbg2w_pkg;

    localparam int BYTE_BITS   = 8;
    localparam int FRAME_SLOTS = BYTE_BITS + 1;
    localparam int SLOT_W      = $clog2(FRAME_SLOTS + 1);

    typedef logic [SLOT_W-1:0]    slot_t;
    typedef logic [BYTE_BITS-1:0] byte_t;

    localparam slot_t SLOT_NONE  = slot_t'(0);
    localparam slot_t SLOT_FIRST = slot_t'(1);
    localparam slot_t SLOT_LAST  = slot_t'(FRAME_SLOTS);
    localparam slot_t SLOT_DLAST = slot_t'(BYTE_BITS);

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_ACTIVE = 1'b1
    } link_state_e;

    // Synchronized line view plus edge events, one system clock wide.
    typedef struct packed {
        logic scl;
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
    } line_evt_t;

    // Slot counter advances on each falling serial clock, wrapping after the gap slot.
    function automatic slot_t next_slot(input slot_t s);
        return (s == SLOT_LAST) ? SLOT_FIRST : s + slot_t'(1);
    endfunction

    function automatic logic is_data_slot(input slot_t s);
        return (s >= SLOT_FIRST) && (s <= SLOT_DLAST);
    endfunction

endpackage

// File: rtl/dbg2w_sync.sv
module dbg2w_sync
    import dbg2w_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      scl_in,
    input  logic      sda_in,
    output line_evt_t evt
);
    localparam int LANES = 2;

    logic [LANES-1:0] raw;
    logic [LANES-1:0] cur;
    logic [LANES-1:0] prev;

    assign raw = {sda_in, scl_in};

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst) chain <= '1;
            else     chain <= {chain[STAGES-2:0], raw[g]};
        end
        assign cur[g] = chain[STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (rst) prev <= '1;
        else     prev <= cur;
    end

    always_comb begin
        evt.scl      = cur[0];
        evt.sda      = cur[1];
        evt.scl_rise = cur[0] & ~prev[0];
        evt.scl_fall = ~cur[0] & prev[0];
        // Data falls while the clock is high in both samples.
        evt.start    = cur[0] & prev[0] & prev[1] & ~cur[1];
    end

endmodule

// File: rtl/dbg2w_framer.sv
module dbg2w_framer
    import dbg2w_pkg::*;
#(
    parameter int HOLD_CYCLES = 64
) (
    input  logic        clk,
    input  logic        rst,
    input  line_evt_t   evt,
    input  logic        hdr_bit0,
    output link_state_e state,
    output slot_t       slot,
    output logic        hdr_phase,
    output logic        read_mode,
    output logic        end_evt,
    output logic        shift_fall,
    output logic        sample_rise,
    output logic        load_evt
);
    localparam int HW = $clog2(HOLD_CYCLES + 1);
    localparam logic [HW-1:0] HOLD_LIM = HW'(HOLD_CYCLES - 1);

    logic [HW-1:0] hold_cnt;
    slot_t         slot_nx;
    logic          live;

    assign slot_nx = next_slot(slot);
    assign live    = (state == ST_ACTIVE) && !evt.start;

    always_comb begin
        end_evt     = live && evt.scl_fall && (slot_nx == SLOT_LAST);
        shift_fall  = live && evt.scl_fall && read_mode &&
                      (slot_nx > SLOT_FIRST) && (slot_nx <= SLOT_DLAST);
        sample_rise = live && evt.scl_rise && !read_mode && is_data_slot(slot);
        load_evt    = end_evt && (read_mode || (hdr_phase && hdr_bit0));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            slot      <= SLOT_NONE;
            hdr_phase <= 1'b0;
            read_mode <= 1'b0;
            hold_cnt  <= '0;
        end else if (evt.start) begin
            state     <= ST_ACTIVE;
            slot      <= SLOT_NONE;
            hdr_phase <= 1'b1;
            read_mode <= 1'b0;
            hold_cnt  <= '0;
        end else if (state == ST_ACTIVE) begin
            if (evt.scl_fall) begin
                slot <= slot_nx;
                if (slot_nx == SLOT_LAST && hdr_phase) begin
                    read_mode <= hdr_bit0;
                    hdr_phase <= 1'b0;
                end
            end
            if (slot == SLOT_LAST && evt.scl && !evt.scl_fall) begin
                if (hold_cnt == HOLD_LIM) begin
                    state    <= ST_IDLE;
                    slot     <= SLOT_NONE;
                    hold_cnt <= '0;
                end else begin
                    hold_cnt <= hold_cnt + 1'b1;
                end
            end else begin
                hold_cnt <= '0;
            end
        end
    end

endmodule

// File: rtl/dbg2w_datapath.sv
module dbg2w_datapath
    import dbg2w_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  sda_bit,
    input  logic  sample_rise,
    input  logic  shift_fall,
    input  logic  load_evt,
    input  byte_t tx_byte,
    output byte_t rx_byte,
    output logic  tx_msb,
    output logic  hdr_bit0
);
    byte_t rx_sh;
    byte_t tx_sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_sh <= '0;
        end else if (sample_rise) begin
            rx_sh <= {rx_sh[BYTE_BITS-2:0], sda_bit};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_sh <= '1;
        end else if (load_evt) begin
            tx_sh <= tx_byte;
        end else if (shift_fall) begin
            tx_sh <= {tx_sh[BYTE_BITS-2:0], 1'b1};
        end
    end

    assign rx_byte  = rx_sh;
    assign tx_msb   = tx_sh[BYTE_BITS-1];
    assign hdr_bit0 = rx_sh[0];

endmodule

// File: rtl/dbg2w_slave.sv
module dbg2w_slave
    import dbg2w_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int HOLD_CYCLES = 64
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_in,
    input  logic       sda_in,
    output logic       sda_o,
    output logic       sda_oe,
    output logic [7:0] rx_data,
    output logic       rx_valid,
    output logic       rx_hdr,
    input  logic [7:0] tx_data,
    output logic       tx_take
);
    line_evt_t   evt;
    link_state_e fr_state;
    slot_t       fr_slot;
    logic        hdr_phase, read_mode;
    logic        end_evt, shift_fall, sample_rise, load_evt;
    logic        hdr_bit0;
    byte_t       rx_byte;
    logic        start_evt;

    dbg2w_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .scl_in (scl_in),
        .sda_in (sda_in),
        .evt    (evt)
    );

    dbg2w_framer #(.HOLD_CYCLES(HOLD_CYCLES)) u_framer (
        .clk         (clk),
        .rst         (rst),
        .evt         (evt),
        .hdr_bit0    (hdr_bit0),
        .state       (fr_state),
        .slot        (fr_slot),
        .hdr_phase   (hdr_phase),
        .read_mode   (read_mode),
        .end_evt     (end_evt),
        .shift_fall  (shift_fall),
        .sample_rise (sample_rise),
        .load_evt    (load_evt)
    );

    dbg2w_datapath u_dp (
        .clk         (clk),
        .rst         (rst),
        .sda_bit     (evt.sda),
        .sample_rise (sample_rise),
        .shift_fall  (shift_fall),
        .load_evt    (load_evt),
        .tx_byte     (tx_data),
        .rx_byte     (rx_byte),
        .tx_msb      (sda_o),
        .hdr_bit0    (hdr_bit0)
    );

    assign start_evt = evt.start;

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_valid <= 1'b0;
            rx_hdr   <= 1'b0;
            rx_data  <= '0;
            tx_take  <= 1'b0;
        end else begin
            rx_valid <= end_evt && !read_mode;
            tx_take  <= load_evt;
            if (end_evt && !read_mode) begin
                rx_data <= rx_byte;
                rx_hdr  <= hdr_phase;
            end
        end
    end

    assign sda_oe = (fr_state == ST_ACTIVE) && read_mode && is_data_slot(fr_slot);

endmodule

// File: rtl/dbg2w_slave_chk.sv
module dbg2w_slave_chk
    import dbg2w_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input link_state_e st,
    input logic        start_evt,
    input logic        rx_valid,
    input logic        tx_take,
    input logic        sda_oe
);
    assert_idle_silent_R1: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE) |=> !rx_valid && !tx_take);

    assert_rx_pulse_R3: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);

    assert_tx_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        tx_take |=> !tx_take);

    assert_no_oe_on_rx_R5: assert property (@(posedge clk) disable iff (rst)
        rx_valid |-> !sda_oe);

    assert_oe_idle_R6: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE) |-> !sda_oe);

    assert_idle_holds_R7: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE && !start_evt) |=> (st == ST_IDLE));

    assert_start_opens_R8: assert property (@(posedge clk) disable iff (rst)
        start_evt |=> (st == ST_ACTIVE) && !sda_oe);

endmodule

bind dbg2w_slave dbg2w_slave_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .st        (fr_state),
    .start_evt (start_evt),
    .rx_valid  (rx_valid),
    .tx_take   (tx_take),
    .sda_oe    (sda_oe)
);

// File: tb/dbg2w_slave_tb.sv
module dbg2w_slave_tb_top;

    localparam int HOLD = 64;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_line;
    logic       sda_o, sda_oe;
    logic [7:0] rx_data;
    logic       rx_valid, rx_hdr;
    logic [7:0] tx_data;
    logic       tx_take;

    int n_tests = 0;
    int n_fail  = 0;
    logic done = 1'b0;

    logic [7:0] rx_log [16];
    logic       rx_hl  [16];
    int         rx_n = 0;
    logic [7:0] txq [4];
    int         txi = 0;
    logic       rd_win = 1'b0;
    int         oe_bad = 0;

    always #5 clk = ~clk;

    assign sda_line = sda_m & ~(sda_oe & ~sda_o);

    always_comb tx_data = (txi < 4) ? txq[txi] : 8'h00;

    dbg2w_slave #(.HOLD_CYCLES(HOLD)) dut_i (
        .clk      (clk),
        .rst      (rst),
        .scl_in   (scl),
        .sda_in   (sda_line),
        .sda_o    (sda_o),
        .sda_oe   (sda_oe),
        .rx_data  (rx_data),
        .rx_valid (rx_valid),
        .rx_hdr   (rx_hdr),
        .tx_data  (tx_data),
        .tx_take  (tx_take)
    );

    always @(negedge clk) begin
        if (rx_valid && rx_n < 16) begin
            rx_log[rx_n] = rx_data;
            rx_hl[rx_n]  = rx_hdr;
            rx_n = rx_n + 1;
        end
        if (tx_take) txi = txi + 1;
        if (sda_oe && !rd_win) oe_bad = oe_bad + 1;
    end

    task automatic check(input logic ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(input logic b, input logic glitch, output logic r, output logic oe_s);
        scl = 1'b0; wait_clk(4);
        sda_m = b;  wait_clk(4);
        scl = 1'b1; wait_clk(4);
        r = sda_line; oe_s = sda_oe;
        if (glitch) sda_m = 1'b1;
        wait_clk(4);
    endtask

    task automatic gap_cycle();
        scl = 1'b0; sda_m = 1'b1; wait_clk(4);
        rd_win = 1'b0; wait_clk(4);
        scl = 1'b1; wait_clk(8);
    endtask

    task automatic start_cond();
        scl = 1'b1; wait_clk(4);
        sda_m = 1'b1; wait_clk(8);
        sda_m = 1'b0; wait_clk(8);
    endtask

    task automatic write_byte(input logic [7:0] v, input logic glitch);
        logic r, o;
        for (int i = 7; i >= 0; i--) send_bit(v[i], glitch, r, o);
        gap_cycle();
    endtask

    task automatic read_byte(output logic [7:0] v, output logic oe_ok);
        logic r, o;
        oe_ok = 1'b1;
        rd_win = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            send_bit(1'b1, 1'b0, r, o);
            v[i] = r;
            oe_ok = oe_ok & o;
        end
        gap_cycle();
    endtask

    task automatic hold_idle();
        scl = 1'b1; sda_m = 1'b1; wait_clk(HOLD + 16);
    endtask

    // {header, byte count, d0, d1, d2}
    localparam logic [39:0] VEC [4] = '{
        {8'h42, 8'd2, 8'hA5, 8'h3C, 8'h00},
        {8'h00, 8'd1, 8'hFF, 8'h00, 8'h00},
        {8'h81, 8'd2, 8'hC3, 8'h5A, 8'h00},
        {8'h27, 8'd1, 8'h96, 8'h00, 8'h00}
    };

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] rv;
        logic       ok;
        logic [7:0] d [3];
        txq = '{8'h00, 8'h00, 8'h00, 8'h00};
        wait_clk(5);
        // R9: reset state
        check(!rx_valid && !tx_take && !sda_oe, "R9", {rx_valid, tx_take, sda_oe}, 0);
        rst = 1'b0;
        wait_clk(5);
        check(!sda_oe && !rx_valid, "R9 after release", {rx_valid, sda_oe}, 0);

        // R1: traffic without a start is ignored
        write_byte(8'h81, 1'b0);
        write_byte(8'h3C, 1'b0);
        check(rx_n == 0 && txi == 0, "R1 no start", rx_n + txi, 0);

        // Table walk: R3, R4, R5
        for (int v = 0; v < 4; v++) begin
            logic [7:0] hdr, cnt;
            {hdr, cnt, d[0], d[1], d[2]} = VEC[v];
            rx_n = 0; txi = 0;
            txq = '{d[0], d[1], d[2], 8'hEE};
            start_cond();
            write_byte(hdr, 1'b0);
            if (hdr[0]) begin
                for (int k = 0; k < int'(cnt); k++) begin
                    read_byte(rv, ok);
                    check(rv == d[k], "R4 read data", rv, d[k]);
                    check(ok, "R6 oe during read bits", ok, 1);
                end
                check(rx_n == 1 && rx_log[0] == hdr && rx_hl[0], "R5 read reports header only", rx_n, 1);
                check(txi == int'(cnt) + 1, "R4 tx_take count", txi, int'(cnt) + 1);
            end else begin
                for (int k = 0; k < int'(cnt); k++) write_byte(d[k], 1'b0);
                check(rx_n == int'(cnt) + 1, "R5 write byte count", rx_n, int'(cnt) + 1);
                check(rx_log[0] == hdr && rx_hl[0], "R3 header byte", rx_log[0], hdr);
                for (int k = 0; k < int'(cnt); k++)
                    check(rx_log[k+1] == d[k] && !rx_hl[k+1], "R3 data byte", rx_log[k+1], d[k]);
                check(txi == 0, "R5 no tx_take in write", txi, 0);
            end
            hold_idle();
        end

        // R7: after hold timeout, bytes without start are ignored
        rx_n = 0; txi = 0;
        write_byte(8'h55, 1'b0);
        write_byte(8'hAA, 1'b0);
        check(rx_n == 0 && txi == 0, "R7 idle after hold", rx_n + txi, 0);
        hold_idle();

        // R8: restart in the middle of a byte
        rx_n = 0;
        start_cond();
        write_byte(8'h10, 1'b0);
        begin
            logic r, o;
            for (int i = 0; i < 3; i++) send_bit(1'b0, 1'b0, r, o);
        end
        start_cond();
        write_byte(8'h20, 1'b0);
        write_byte(8'h77, 1'b0);
        check(rx_n == 3, "R8 byte count", rx_n, 3);
        check(rx_log[1] == 8'h20 && rx_hl[1], "R8 new header", rx_log[1], 8'h20);
        check(rx_log[2] == 8'h77 && !rx_hl[2], "R8 data after restart", rx_log[2], 8'h77);
        hold_idle();

        // R2: data rising while clock high leaves samples and framing intact
        rx_n = 0;
        start_cond();
        write_byte(8'h00, 1'b0);
        write_byte(8'h00, 1'b1);
        write_byte(8'h5A, 1'b0);
        check(rx_n == 3, "R2 byte count", rx_n, 3);
        check(rx_log[1] == 8'h00 && !rx_hl[1], "R2 sampled bits kept", rx_log[1], 0);
        check(rx_log[2] == 8'h5A, "R2 framing intact", rx_log[2], 8'h5A);
        hold_idle();

        // R6: enable never seen outside read data cycles
        check(oe_bad == 0, "R6 oe outside window", oe_bad, 0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule